// File: doc/BRIEF.md
# Three-Region Banked Address Translator

This block sits between an 8-bit processor core and a 1 MB physical memory space. It turns each 16-bit logical address into a 20-bit physical address. The low 12 bits, a 4 KB page offset, pass through unchanged. The 4-bit logical page decides which of three consecutive regions the address falls in: a low common region starting at logical zero, a middle bank region, and a high common region running to the top of logical space.

Two 4-bit boundaries, packed into one configuration byte, set the first page of the bank region and the first page of the high common region. The low region is never relocated. Each of the other two regions adds its own 8-bit base to the logical page, and the sum wraps modulo 256 pages. Software normally leaves the two common regions fixed and rewrites the bank base to switch banks at run time.

Registers are loaded through a single-cycle write port and read back through a combinational read port. Translation itself is purely combinational.

Top module: `bank_xlate`

## Requirements
- R1: Physical address bits [11:0] always equal logical address bits [11:0].
- R2: A logical page below both boundaries is passed through untranslated. The physical page is the logical page with four zero bits above it.
- R3: A logical page at or above the bank boundary (boundary byte bits [3:0]) and below the high common boundary (boundary byte bits [7:4]) gets the bank base added. The physical page is (page + bank base) mod 256.
- R4: A logical page at or above the high common boundary gets the common base added. The physical page is (page + common base) mod 256.
- R5: If the high common boundary is at or below the bank boundary, the bank region is empty. The high common check wins, and pages below the high common boundary use the low-region rule.
- R6: While reset is held and after it is released, the boundary byte reads 0xFF and both bases read 0x00. Translation is then the identity for every logical address.
- R7: Register select codes are 0 for the boundary byte, 1 for the bank base and 2 for the common base. A write with the write enable high loads the selected register at the next rising clock edge, and the read port returns the current contents of the selected register.
- R8: Select code 3 addresses no register. A write to it changes nothing, and a read from it returns 0x00.
- R9: The physical address follows a change of logical address in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select for writes |
| cfg_wdata | input | 8 | Write data |
| cfg_rsel | input | 2 | Register select for readback |
| cfg_rdata | output | 8 | Readback data |
| lg_addr | input | 16 | Logical address from the core |
| ph_addr | output | 20 | Translated physical address |

## Verification
The case that is hardest to reach is an inverted boundary byte, where the high common boundary is at or below the bank boundary. It only shows up when software programs an unusual layout, and it is the only case where the two region compares disagree about priority. The vector table loads such a byte and probes pages on both sides of the high common boundary. It also loads an all-zero byte, so that every page is in the high region. Separate vectors push both relocation sums past page 255, so that wrap-around is seen in the bank region and in the high region.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;
  typedef enum logic [1:0] {
    SEL_BND   = 2'd0,
    SEL_BBASE = 2'd1,
    SEL_CBASE = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  localparam int unsigned NUM_RELOC = 2;
  localparam int unsigned RELOC_BANK = 0;
  localparam int unsigned RELOC_HIGH = 1;
endpackage

// File: rtl/bank_xlate_rst_sync.sv
module bank_xlate_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bank_xlate_cfg.sv
module bank_xlate_cfg
  import bank_xlate_pkg::*;
#(
  parameter int unsigned LPAGE_W = 4,
  parameter int unsigned PPAGE_W = 8,
  localparam int unsigned DATA_W = PPAGE_W,
  localparam int unsigned BND_W  = 2 * LPAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        rsel,
  output logic [DATA_W-1:0] rdata,
  output logic [BND_W-1:0]  bnd_q,
  output logic [PPAGE_W-1:0] bbase_q,
  output logic [PPAGE_W-1:0] cbase_q
);
  logic               bnd_en, bbase_en, cbase_en;
  logic [BND_W-1:0]   bnd_d;
  logic [PPAGE_W-1:0] bbase_d, cbase_d;

  always_comb begin
    bnd_en   = we && (cfg_sel_e'(sel) == SEL_BND);
    bbase_en = we && (cfg_sel_e'(sel) == SEL_BBASE);
    cbase_en = we && (cfg_sel_e'(sel) == SEL_CBASE);
    bnd_d    = wdata[BND_W-1:0];
    bbase_d  = wdata[PPAGE_W-1:0];
    cbase_d  = wdata[PPAGE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q   <= '1;
      bbase_q <= '0;
      cbase_q <= '0;
    end else begin
      if (bnd_en)   bnd_q   <= bnd_d;
      if (bbase_en) bbase_q <= bbase_d;
      if (cbase_en) cbase_q <= cbase_d;
    end
  end

  always_comb begin
    unique case (cfg_sel_e'(rsel))
      SEL_BND:   rdata = DATA_W'(bnd_q);
      SEL_BBASE: rdata = bbase_q;
      SEL_CBASE: rdata = cbase_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/bank_xlate_map.sv
module bank_xlate_map
  import bank_xlate_pkg::*;
#(
  parameter int unsigned LPAGE_W = 4,
  parameter int unsigned PPAGE_W = 8,
  parameter int unsigned OFS_W   = 12,
  localparam int unsigned LOG_W  = LPAGE_W + OFS_W,
  localparam int unsigned PHYS_W = PPAGE_W + OFS_W
) (
  input  logic [LOG_W-1:0]     lg_addr,
  input  logic [2*LPAGE_W-1:0] bnd,
  input  logic [PPAGE_W-1:0]   bbase,
  input  logic [PPAGE_W-1:0]   cbase,
  output logic [PHYS_W-1:0]    ph_addr
);
  logic [LPAGE_W-1:0] page;
  logic [LPAGE_W-1:0] bank_start, high_start;
  logic [PPAGE_W-1:0] page_ext;
  logic [PPAGE_W-1:0] base   [NUM_RELOC];
  logic [PPAGE_W-1:0] reloc  [NUM_RELOC];
  logic               in_bank, in_high;
  logic [PPAGE_W-1:0] ppage;

  assign page       = lg_addr[LOG_W-1:OFS_W];
  assign bank_start = bnd[LPAGE_W-1:0];
  assign high_start = bnd[2*LPAGE_W-1:LPAGE_W];
  assign page_ext   = {{(PPAGE_W-LPAGE_W){1'b0}}, page};
  assign base[RELOC_BANK] = bbase;
  assign base[RELOC_HIGH] = cbase;

  for (genvar i = 0; i < NUM_RELOC; i++) begin : g_reloc
    assign reloc[i] = page_ext + base[i];
  end

  always_comb begin
    in_high = (page >= high_start);
    in_bank = (page >= bank_start);
    if (in_high)      ppage = reloc[RELOC_HIGH];
    else if (in_bank) ppage = reloc[RELOC_BANK];
    else              ppage = page_ext;
  end

  assign ph_addr = {ppage, lg_addr[OFS_W-1:0]};
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int unsigned LPAGE_W = 4,
  parameter int unsigned PPAGE_W = 8,
  parameter int unsigned OFS_W   = 12,
  localparam int unsigned LOG_W  = LPAGE_W + OFS_W,
  localparam int unsigned PHYS_W = PPAGE_W + OFS_W,
  localparam int unsigned DATA_W = PPAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [1:0]        cfg_rsel,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [LOG_W-1:0]  lg_addr,
  output logic [PHYS_W-1:0] ph_addr
);
  logic                 rst_sync_n;
  logic [2*LPAGE_W-1:0] bnd_q;
  logic [PPAGE_W-1:0]   bbase_q, cbase_q;

  bank_xlate_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bank_xlate_cfg #(.LPAGE_W(LPAGE_W), .PPAGE_W(PPAGE_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .rsel    (cfg_rsel),
    .rdata   (cfg_rdata),
    .bnd_q   (bnd_q),
    .bbase_q (bbase_q),
    .cbase_q (cbase_q)
  );

  bank_xlate_map #(.LPAGE_W(LPAGE_W), .PPAGE_W(PPAGE_W), .OFS_W(OFS_W)) u_map (
    .lg_addr (lg_addr),
    .bnd     (bnd_q),
    .bbase   (bbase_q),
    .cbase   (cbase_q),
    .ph_addr (ph_addr)
  );
endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
  parameter int unsigned LPAGE_W = 4,
  parameter int unsigned PPAGE_W = 8,
  parameter int unsigned OFS_W   = 12,
  localparam int unsigned LOG_W  = LPAGE_W + OFS_W,
  localparam int unsigned PHYS_W = PPAGE_W + OFS_W
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 cfg_we,
  input logic [1:0]           cfg_sel,
  input logic [PPAGE_W-1:0]   cfg_wdata,
  input logic [1:0]           cfg_rsel,
  input logic [PPAGE_W-1:0]   cfg_rdata,
  input logic [LOG_W-1:0]     lg_addr,
  input logic [PHYS_W-1:0]    ph_addr,
  input logic [2*LPAGE_W-1:0] bnd_q,
  input logic [PPAGE_W-1:0]   bbase_q,
  input logic [PPAGE_W-1:0]   cbase_q
);
  logic [LPAGE_W-1:0] pg;
  logic [PPAGE_W-1:0] pg_w;
  logic [PPAGE_W-1:0] out_pg;
  assign pg     = lg_addr[LOG_W-1:OFS_W];
  assign pg_w   = PPAGE_W'(pg);
  assign out_pg = ph_addr[PHYS_W-1:OFS_W];

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ph_addr[OFS_W-1:0] == lg_addr[OFS_W-1:0]);

  assert_low_identity_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pg < bnd_q[LPAGE_W-1:0] && pg < bnd_q[2*LPAGE_W-1:LPAGE_W]) |-> out_pg == pg_w);

  assert_bank_reloc_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pg >= bnd_q[LPAGE_W-1:0] && pg < bnd_q[2*LPAGE_W-1:LPAGE_W])
      |-> out_pg == PPAGE_W'(pg_w + bbase_q));

  assert_high_priority_R4_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pg >= bnd_q[2*LPAGE_W-1:LPAGE_W]) |-> out_pg == PPAGE_W'(pg_w + cbase_q));

  assert_bank_write_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_sel == 2'd1) |=> bbase_q == $past(cfg_wdata));

  assert_hold_no_write_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_we || cfg_sel == 2'd3) |=> ($stable(bnd_q) && $stable(bbase_q) && $stable(cbase_q)));

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_rsel == 2'd3) |-> cfg_rdata == '0);
endmodule

bind bank_xlate bank_xlate_chk #(.LPAGE_W(LPAGE_W), .PPAGE_W(PPAGE_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .cfg_rsel   (cfg_rsel),
  .cfg_rdata  (cfg_rdata),
  .lg_addr    (lg_addr),
  .ph_addr    (ph_addr),
  .bnd_q      (bnd_q),
  .bbase_q    (bbase_q),
  .cbase_q    (cbase_q)
);

// File: tb/bank_xlate_bench.sv
`timescale 1ns/1ps
module bank_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [1:0]  cfg_rsel;
  logic [7:0]  cfg_rdata;
  logic [15:0] lg_addr;
  logic [19:0] ph_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bank_xlate u_bank_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .lg_addr(lg_addr), .ph_addr(ph_addr)
  );

  typedef struct packed {
    logic [7:0]  bnd;
    logic [7:0]  bb;
    logic [7:0]  cb;
    logic [15:0] la;
    logic [19:0] pa;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'hC4, 8'h10, 8'h30, 16'h1234, 20'h01234, 4'd2}, // R2 low page
    '{8'hC4, 8'h10, 8'h30, 16'h3FFF, 20'h03FFF, 4'd2}, // R2 just below bank
    '{8'hC4, 8'h10, 8'h30, 16'h4ABC, 20'h14ABC, 4'd3}, // R3 first bank page
    '{8'hC4, 8'h10, 8'h30, 16'hBFFF, 20'h1BFFF, 4'd3}, // R3 last bank page
    '{8'hC4, 8'h10, 8'h30, 16'hC000, 20'h3C000, 4'd4}, // R4 first high page
    '{8'h84, 8'hFE, 8'h00, 16'h5001, 20'h03001, 4'd3}, // R3 wrap
    '{8'h84, 8'hFE, 8'hF9, 16'hF777, 20'h08777, 4'd4}, // R4 wrap
    '{8'h48, 8'h20, 8'h50, 16'h6000, 20'h56000, 4'd5}, // R5 inverted, high wins
    '{8'h48, 8'h20, 8'h50, 16'h3123, 20'h03123, 4'd5}, // R5 inverted, low below
    '{8'h00, 8'h20, 8'h50, 16'h0ABC, 20'h50ABC, 4'd5}, // R5 all high
    '{8'hF0, 8'h20, 8'h50, 16'h0000, 20'h20000, 4'd3}  // R3 bank from page 0
  };

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [1:0] sel, input logic [7:0] exp);
    cfg_rsel = sel;
    #1;
    check(tag, {12'h0, cfg_rdata}, {12'h0, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'h00;
    cfg_rsel = 2'd0; lg_addr = 16'h0000;
    repeat (3) @(negedge clk);
    // R6: values while reset is held
    rd_check("R6 bnd in reset", 2'd0, 8'hFF);
    lg_addr = 16'hF123; #1;
    check("R6 identity in reset", ph_addr, 20'h0F123);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6: after release
    rd_check("R6 bnd", 2'd0, 8'hFF);
    rd_check("R6 bank base", 2'd1, 8'h00);
    rd_check("R6 common base", 2'd2, 8'h00);
    lg_addr = 16'h7A5A; #1;
    check("R6 identity page 7", ph_addr, 20'h07A5A);
    lg_addr = 16'hFFFF; #1;
    check("R6 identity page 15", ph_addr, 20'h0FFFF);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VECS[i].bnd);
      wr(2'd1, VECS[i].bb);
      wr(2'd2, VECS[i].cb);
      lg_addr = VECS[i].la;
      #1;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), ph_addr, VECS[i].pa);
      check($sformatf("R1 offset vector %0d", i), {8'h0, ph_addr[11:0]}, {8'h0, VECS[i].la[11:0]});
    end

    // R7: write takes effect only at the edge
    wr(2'd0, 8'hC4); wr(2'd1, 8'h10); wr(2'd2, 8'h30);
    lg_addr = 16'h5000;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'h40;
    #1;
    check("R7 before edge", ph_addr, 20'h15000);
    rd_check("R7 readback before edge", 2'd1, 8'h10);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R7 after edge", ph_addr, 20'h45000);
    rd_check("R7 readback bank base", 2'd1, 8'h40);
    rd_check("R7 readback bnd", 2'd0, 8'hC4);
    rd_check("R7 readback common base", 2'd2, 8'h30);

    // R8: unmapped select
    wr(2'd3, 8'hAA);
    rd_check("R8 bnd untouched", 2'd0, 8'hC4);
    rd_check("R8 bank base untouched", 2'd1, 8'h40);
    rd_check("R8 common base untouched", 2'd2, 8'h30);
    rd_check("R8 read zero", 2'd3, 8'h00);
    check("R8 translation untouched", ph_addr, 20'h45000);

    // R9: combinational path, no edge between changes
    @(posedge clk); #0.5;
    lg_addr = 16'hD00F; #0.5;
    check("R9 high region same cycle", ph_addr, 20'h3D00F);
    lg_addr = 16'h0321; #0.5;
    check("R9 low region same cycle", ph_addr, 20'h00321);

    // R6: reset reapplied restores defaults
    @(negedge clk);
    rst_n = 1'b0; #1;
    rd_check("R6 bank base after re-reset", 2'd1, 8'h00);
    lg_addr = 16'hC000; #1;
    check("R6 identity after re-reset", ph_addr, 20'h0C000);

    finish_run();
  end
endmodule